// File: doc/BRIEF.md
# DDR3 ZQ Calibration Scheduler

This block lives inside a DDR3 memory controller and decides when impedance calibration commands go out to the DRAM. Out of reset it owes the device one long calibration. After that it paces short calibrations with a programmable interval counter, so that drift in voltage and temperature stays tracked. It also takes a long calibration on demand from the rest of the controller.

The block asks the command arbiter for a slot through a request/grant pair. A calibration command is only legal when no bank is open and the precharge time has run out. While a bank is still open, the block asks for a precharge-all instead. Once a calibration command goes out, the busy flag tells the arbiter to keep all other traffic away for the blackout length. That length is one of three values: the first long calibration after reset, any later long calibration, or a short one.

Top module: `zq_cal_sched`

## Requirements
- R1: While reset is low and in the first cycle after it, `cmd` is NOP and `busy` is low; with banks idle and `trp_met` high, `zq_req` is high right after reset.
- R2: The first calibration command after reset is a long calibration (`cmd` = 2), and it keeps `busy` high for exactly TINIT cycles, counting the issue cycle.
- R3: Every later long calibration keeps `busy` high for exactly TOPER cycles, counting the issue cycle.
- R4: A short calibration (`cmd` = 3) keeps `busy` high for exactly TCS cycles, counting the issue cycle.
- R5: `busy` is high in the cycle a calibration command is granted and in the cycle after it, and `zq_req` stays low while `busy` is high outside the issue cycle.
- R6: While any bit of `bank_open` is set and a calibration is due, the block requests, and on grant issues, a precharge-all (`cmd` = 1), never a calibration command.
- R7: While `trp_met` is low and no bank is open, the block neither requests nor issues anything.
- R8: After a calibration is issued at clock edge E0 with `interval` = N, a short calibration request appears after edge E0+N+1, provided the blackout has ended by then.
- R9: An on-demand pulse on `long_req` while a short calibration is pending makes the next command a long calibration, and the pending short one is dropped.
- R10: `cmd` is 0 (NOP) in every cycle where `zq_req` and `zq_gnt` are not both high.
- R11: A `long_req` pulse that arrives during a blackout is held and is issued once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open | input | NB | One bit per bank, high while that bank holds an open row |
| trp_met | input | 1 | High once the precharge time has elapsed since the last precharge |
| long_req | input | 1 | One-cycle pulse asking for an on-demand long calibration |
| interval | input | IW | Cycles between a calibration and the next periodic short one, sampled at issue |
| zq_req | output | 1 | Request for a command slot from the arbiter |
| zq_gnt | input | 1 | Grant from the arbiter; a command goes out when request and grant are both high |
| cmd | output | 2 | Command issued this cycle: 0 NOP, 1 precharge-all, 2 long, 3 short |
| busy | output | 1 | Calibration blackout; the arbiter holds other traffic off while high |

## Verification
The bench builds the block with four banks, a 6-bit interval and blackouts of 12, 7 and 3 cycles. These values keep each blackout short, so every bank-open pattern can be swept exhaustively. They also let each interval from 4 to 20 be issued and timed one after another. Because the three blackout lengths differ, a wrong choice between first long, later long and short calibration shows up as a wrong count.

// File: rtl/zq_cal_sched.sv
module zq_cal_sched #(
  parameter int NB    = 8,
  parameter int IW    = 16,
  parameter int TINIT = 512,
  parameter int TOPER = 256,
  parameter int TCS   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bank_open,
  input  logic          trp_met,
  input  logic          long_req,
  input  logic [IW-1:0] interval,
  output logic          zq_req,
  input  logic          zq_gnt,
  output logic [1:0]    cmd,
  output logic          busy
);
  localparam int CW = $clog2(TINIT + 1);
  localparam logic [1:0] C_NOP  = 2'd0;
  localparam logic [1:0] C_PREA = 2'd1;
  localparam logic [1:0] C_LONG = 2'd2;
  localparam logic [1:0] C_SHORT = 2'd3;

  logic          init_done, pend_long, pend_short;
  logic [CW-1:0] blk;
  logic [IW-1:0] ivl;

  wire busy_q   = blk != '0;
  wire due      = pend_long | pend_short;
  wire any_open = |bank_open;

  assign zq_req = due && !busy_q && (any_open || trp_met);

  wire [1:0] want   = any_open ? C_PREA : (pend_long ? C_LONG : C_SHORT);
  wire       fire   = zq_req && zq_gnt;
  wire       zq_go  = fire && !any_open;

  assign cmd  = fire ? want : C_NOP;
  assign busy = busy_q | zq_go;

  wire [CW-1:0] len = pend_long ? (init_done ? CW'(TOPER - 1) : CW'(TINIT - 1))
                                : CW'(TCS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_done  <= 1'b0;
      pend_long  <= 1'b1;
      pend_short <= 1'b0;
      blk        <= '0;
      ivl        <= '0;
    end else begin
      if (zq_go) begin
        blk        <= len;
        ivl        <= interval;
        pend_short <= 1'b0;
        if (pend_long) begin
          pend_long <= 1'b0;
          init_done <= 1'b1;
        end
      end else begin
        if (busy_q) blk <= blk - 1'b1;
        if (ivl != '0) ivl <= ivl - 1'b1;
        else if (init_done && !due) pend_short <= 1'b1;
      end
      if (long_req) pend_long <= 1'b1;
    end
  end
endmodule

module zq_cal_sched_chk #(
  parameter int NB    = 8,
  parameter int TINIT = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] bank_open,
  input logic          trp_met,
  input logic          zq_req,
  input logic          zq_gnt,
  input logic [1:0]    cmd,
  input logic          busy
);
  localparam int RW = $clog2(TINIT + 2);
  logic          seen;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      run  <= '0;
    end else begin
      seen <= seen | cmd[1];
      run  <= busy ? run + 1'b1 : '0;
    end
  end

  // R10
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(zq_req && zq_gnt) |-> cmd == 2'd0);
  // R5
  blackout_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[1] |=> busy);
  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd[1]) |-> !zq_req);
  // R6
  open_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_open) |-> !cmd[1]);
  // R7
  trp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trp_met |-> !cmd[1]);
  // R2
  first_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && cmd[1]) |-> cmd == 2'd2);
  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(TINIT));
endmodule

bind zq_cal_sched zq_cal_sched_chk #(.NB(NB), .TINIT(TINIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .trp_met(trp_met),
  .zq_req(zq_req), .zq_gnt(zq_gnt), .cmd(cmd), .busy(busy)
);

// File: tb/test_zq_cal_sched.sv
module test_zq_cal_sched;
  localparam int NB = 4, IW = 6, TINIT = 12, TOPER = 7, TCS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic          trp_met = 1'b1;
  logic          long_req = 1'b0;
  logic [IW-1:0] interval = IW'(40);
  logic          zq_gnt = 1'b0;
  logic          zq_req, busy;
  logic [1:0]    cmd;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zq_cal_sched #(.NB(NB), .IW(IW), .TINIT(TINIT), .TOPER(TOPER), .TCS(TCS)) i_zq_cal_sched (
    .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .trp_met(trp_met),
    .long_req(long_req), .interval(interval), .zq_req(zq_req), .zq_gnt(zq_gnt),
    .cmd(cmd), .busy(busy)
  );

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic issue(int exp_cmd, int exp_len, int exp_gap, string r);
    int k = 0;
    int blen;
    while (!zq_req && k < 200) begin step; k++; end
    check({r, " R10 nop without grant"}, cmd, 0);
    zq_gnt = 1'b1;
    #1;
    check({r, " cmd"}, cmd, exp_cmd);
    check({r, " R5 busy at issue"}, busy, 1);
    step;
    zq_gnt = 1'b0;
    blen = 1;
    k = 1;
    while (busy && k < 200) begin
      if (zq_req) check({r, " R5 req in blackout"}, 1, 0);
      blen++;
      step;
      k++;
    end
    check({r, " blackout"}, blen, exp_len);
    if (exp_gap > 0) begin
      while (!zq_req && k < 200) begin step; k++; end
      check({r, " R8 gap"}, k, exp_gap);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step;
    check("R1 cmd in reset", cmd, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    step;
    check("R1 cmd after reset", cmd, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 req after reset", zq_req, 1);

    zq_gnt = 1'b1;
    for (int b = 1; b < (1 << NB); b++) begin
      bank_open = NB'(b);
      #1;
      check("R6 req with open bank", zq_req, 1);
      check("R6 precharge-all", cmd, 1);
    end
    zq_gnt = 1'b0;
    bank_open = '0;

    trp_met = 1'b0;
    #1;
    check("R7 no req", zq_req, 0);
    zq_gnt = 1'b1;
    #1;
    check("R7 no cmd", cmd, 0);
    step;
    check("R7 no busy", busy, 0);
    zq_gnt = 1'b0;
    trp_met = 1'b1;

    interval = IW'(40);
    issue(2, TINIT, 40 + 2, "R2");

    for (int iv = 4; iv <= 20; iv++) begin
      interval = IW'(iv);
      issue(3, TCS, iv + 2, "R4 R8");
    end

    long_req = 1'b1;
    step;
    long_req = 1'b0;
    interval = IW'(40);
    issue(2, TOPER, 0, "R9 R3");
    for (int c = 0; c < 20; c++) begin
      check("R9 short dropped", zq_req, 0);
      step;
    end

    interval = IW'(30);
    issue(3, TCS, 0, "R4");
    while (!zq_req) step;
    zq_gnt = 1'b1;
    #1;
    check("R11 short issued", cmd, 3);
    step;
    zq_gnt = 1'b0;
    long_req = 1'b1;
    step;
    long_req = 1'b0;
    check("R11 held in blackout", zq_req, 0);
    issue(2, TOPER, 0, "R11 R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule